// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate SRAM

This block is a small synchronous memory with two data paths that never share wires. Reads come out on a dedicated output bus and writes go in on a dedicated input bus, so a read and a write can both be started in the same clock period. One address bus serves both ports. Its value at the rising clock edge is the read address. Its value at the falling clock edge is the write address. The falling edge stands in for the rising edge of the complementary clock.

Each address holds a pair of 18-bit words. Every access moves both words, one per half period. Two active-low lane enables sit on the write side and mask each write word in two 9-bit lanes. A read returns the pair 1.5 periods after its address was taken. The first word appears on the falling edge and the second on the next rising edge. A read that hits the address being written in the same period returns the merged new contents. The number of pair locations is set by a parameter.

Top module: `qdr_b2_sram`

## Requirements
- R1: While reset is asserted, and after it is released until the first read, `rdata` is zero in both halves of every period.
- R2: A read selected at rising edge k returns its first word from falling edge k+1 and its second word from rising edge k+2. In every half period that carries no read word, `rdata` is zero.
- R3: A write stores the `wdata` seen at the rising edge as the first word and the `wdata` seen at the following falling edge as the second word. A later read returns the two words in that order.
- R4: `addr` at the rising edge is the read address and `addr` at the falling edge of the same period is the write address. A read and a write to different locations in one period are both carried out.
- R5: `bw_n[0]` low enables bits 8:0 and `bw_n[1]` low enables bits 17:9. `bw_n` is sampled separately with each write word, and disabled lanes keep their old contents.
- R6: A read and a write to the same address in the same period return the merged new contents, with lane masks applied.
- R7: With `wr_sel_n` high at the falling edge, nothing is stored. With `rd_sel_n` high at the rising edge, no word is driven.
- R8: Reads issued in consecutive periods give an unbroken stream of words, one per half period.
- R9: A write in one period is visible to a read in the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the rising edge and the falling edge both sample inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released inside the block on a rising edge |
| addr | input | ADDR_W | Shared address: read address at the rising edge, write address at the falling edge |
| rd_sel_n | input | 1 | Active-low read select, sampled at the rising edge |
| wr_sel_n | input | 1 | Active-low write select, sampled at the falling edge |
| wdata | input | 18 | Write word: first word at the rising edge, second word at the falling edge |
| bw_n | input | 2 | Active-low lane enables, sampled with each write word |
| rdata | output | 18 | Read word: first word in the low phase, second word in the high phase |

## Verification
The hardest case to reach is a read and a write to the same location in the same period with only some lanes enabled. At that moment the write has not yet reached the array, and the read must merge old and new data lane by lane. The stimulus first fills a location completely. It then issues one period in which `addr` carries the same value on both edges, `rd_sel_n` and `wr_sel_n` are both low, and `bw_n` enables a different lane for each of the two words. A full-lane variant of the same collision and a write followed by a read in the very next period come close to the same logic from both sides.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;

  localparam int WORD_W = 18;
  localparam int LANES  = 2;
  localparam int LANE_W = WORD_W / LANES;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_en_t;

  // lo is the word transferred first, hi the word transferred second
  typedef struct packed {
    word_t lo;
    word_t hi;
  } pair_t;

  function automatic word_t lane_merge(word_t old_w, word_t new_w, lane_en_t en);
    word_t res;
    res = old_w;
    for (int b = 0; b < LANES; b++) begin
      if (en[b]) res[b*LANE_W +: LANE_W] = new_w[b*LANE_W +: LANE_W];
    end
    return res;
  endfunction

endpackage

// File: rtl/qdr_b2_wr_capture.sv
module qdr_b2_wr_capture
  import qdr_b2_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_sel_n,
  input  word_t             wdata,
  input  lane_en_t          bw_n,
  output logic              cm_vld,
  output logic [ADDR_W-1:0] cm_addr,
  output word_t             cm_lo,
  output word_t             cm_hi,
  output lane_en_t          cm_en_lo,
  output lane_en_t          cm_en_hi
);

  // rising-edge half: first word and its lane enables
  word_t    lo_q, lo_d;
  lane_en_t en_lo_q, en_lo_d;

  always_comb begin
    lo_d    = wdata;
    en_lo_d = ~bw_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      en_lo_q <= '0;
    end else begin
      lo_q    <= lo_d;
      en_lo_q <= en_lo_d;
    end
  end

  // falling-edge half: select, write address, second word
  logic              vld_q, vld_d, load_en;
  logic [ADDR_W-1:0] addr_q;
  word_t             hi_q;
  lane_en_t          en_hi_q;

  always_comb begin
    vld_d   = ~wr_sel_n;
    load_en = ~wr_sel_n;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      addr_q  <= '0;
      hi_q    <= '0;
      en_hi_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (load_en) begin
        addr_q  <= addr;
        hi_q    <= wdata;
        en_hi_q <= ~bw_n;
      end
    end
  end

  always_comb begin
    cm_vld   = vld_q;
    cm_addr  = addr_q;
    cm_lo    = lo_q;
    cm_hi    = hi_q;
    cm_en_lo = en_lo_q;
    cm_en_hi = en_hi_q;
  end

endmodule

// File: rtl/qdr_b2_pair_array.sv
module qdr_b2_pair_array
  import qdr_b2_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  word_t             wlo,
  input  word_t             whi,
  input  lane_en_t          wen_lo,
  input  lane_en_t          wen_hi,
  input  logic [ADDR_W-1:0] raddr,
  output pair_t             rpair
);

  localparam int DEPTH = 1 << ADDR_W;

  word_t mem_lo [DEPTH];
  word_t mem_hi [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_lo[waddr] <= lane_merge(mem_lo[waddr], wlo, wen_lo);
      mem_hi[waddr] <= lane_merge(mem_hi[waddr], whi, wen_hi);
    end
  end

  always_comb begin
    rpair.lo = mem_lo[raddr];
    rpair.hi = mem_hi[raddr];
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane_chk
    // R5: an enabled lane holds the written bits after the commit edge
    a_r5_lane_store_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wen_lo[b]) |=>
        mem_lo[$past(waddr)][b*LANE_W +: LANE_W] == $past(wlo[b*LANE_W +: LANE_W]));
    a_r5_lane_store_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wen_hi[b]) |=>
        mem_hi[$past(waddr)][b*LANE_W +: LANE_W] == $past(whi[b*LANE_W +: LANE_W]));
  end

endmodule

// File: rtl/qdr_b2_rd_pipe.sv
module qdr_b2_rd_pipe
  import qdr_b2_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_sel_n,
  output logic [ADDR_W-1:0] ar_addr,
  input  pair_t             ar_pair,
  input  logic              cm_vld,
  input  logic [ADDR_W-1:0] cm_addr,
  input  word_t             cm_lo,
  input  word_t             cm_hi,
  input  lane_en_t          cm_en_lo,
  input  lane_en_t          cm_en_hi,
  output word_t             rdata
);

  // stage 1: read request taken on the rising edge
  logic              rv_q;
  logic [ADDR_W-1:0] ra_q;
  logic              req_en;

  always_comb req_en = ~rd_sel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      ra_q <= '0;
    end else begin
      rv_q <= req_en;
      if (req_en) ra_q <= addr;
    end
  end

  // stage 2: array lookup with bypass of the write committing on this edge
  logic  hit;
  pair_t pair_d, pair_q;
  logic  pv_q;

  always_comb begin
    ar_addr   = ra_q;
    hit       = cm_vld && (cm_addr == ra_q);
    pair_d    = ar_pair;
    if (hit) begin
      pair_d.lo = lane_merge(ar_pair.lo, cm_lo, cm_en_lo);
      pair_d.hi = lane_merge(ar_pair.hi, cm_hi, cm_en_hi);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q   <= 1'b0;
      pair_q <= '0;
    end else begin
      pv_q <= rv_q;
      if (rv_q) pair_q <= pair_d;
    end
  end

  // stage 3: double-rate output, one register per edge
  word_t fall_q, fall_d, rise_q, rise_d;

  always_comb begin
    fall_d = pv_q ? pair_q.lo : '0;
    rise_d = pv_q ? pair_q.hi : '0;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= fall_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= rise_d;
  end

  always_comb rdata = clk ? rise_q : fall_q;

  // R2: the low-phase word is the first word of the pair held in stage 2
  a_r2_first_word: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q == (pv_q ? pair_q.lo : '0));

  // R2: the high-phase word is the second word of the pair one edge earlier
  a_r2_second_word: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q == ($past(pv_q) ? $past(pair_q.hi) : '0));

  // R6: a colliding full-lane write is returned by the read
  a_r6_collide_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && cm_vld && cm_addr == ra_q && (&cm_en_lo) && (&cm_en_hi)) |=>
      (pair_q.lo == $past(cm_lo) && pair_q.hi == $past(cm_hi)));

endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram
  import qdr_b2_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [17:0]       wdata,
  input  logic [1:0]        bw_n,
  output logic [17:0]       rdata
);

  localparam int SYNC_N = 2;

  // reset: asserted at once, removed on a rising edge
  logic [SYNC_N-1:0] sync_q;
  logic              rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-2:0], 1'b1};
  end

  always_comb rst_s = sync_q[SYNC_N-1];

  logic              cm_vld;
  logic [ADDR_W-1:0] cm_addr;
  word_t             cm_lo, cm_hi;
  lane_en_t          cm_en_lo, cm_en_hi;
  logic [ADDR_W-1:0] ar_addr;
  pair_t             ar_pair;

  qdr_b2_wr_capture #(.ADDR_W(ADDR_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_s),
    .addr     (addr),
    .wr_sel_n (wr_sel_n),
    .wdata    (wdata),
    .bw_n     (bw_n),
    .cm_vld   (cm_vld),
    .cm_addr  (cm_addr),
    .cm_lo    (cm_lo),
    .cm_hi    (cm_hi),
    .cm_en_lo (cm_en_lo),
    .cm_en_hi (cm_en_hi)
  );

  qdr_b2_pair_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk    (clk),
    .rst_n  (rst_s),
    .we     (cm_vld),
    .waddr  (cm_addr),
    .wlo    (cm_lo),
    .whi    (cm_hi),
    .wen_lo (cm_en_lo),
    .wen_hi (cm_en_hi),
    .raddr  (ar_addr),
    .rpair  (ar_pair)
  );

  qdr_b2_rd_pipe #(.ADDR_W(ADDR_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_s),
    .addr     (addr),
    .rd_sel_n (rd_sel_n),
    .ar_addr  (ar_addr),
    .ar_pair  (ar_pair),
    .cm_vld   (cm_vld),
    .cm_addr  (cm_addr),
    .cm_lo    (cm_lo),
    .cm_hi    (cm_hi),
    .cm_en_lo (cm_en_lo),
    .cm_en_hi (cm_en_hi),
    .rdata    (rdata)
  );

endmodule

// File: tb/qdr_b2_sram_test.sv
module qdr_b2_sram_test;

  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          rd_sel_n, wr_sel_n;
  logic [17:0]   wdata;
  logic [1:0]    bw_n;
  logic [17:0]   rdata;

  qdr_b2_sram #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_sel_n(rd_sel_n),
    .wr_sel_n(wr_sel_n), .wdata(wdata), .bw_n(bw_n), .rdata(rdata)
  );

  always #(CLK_P/2) clk = ~clk;

  int    errs = 0;
  int    checks = 0;
  bit    done = 0;
  string cur_req = "R1";

  logic [17:0] m_lo [DEPTH];
  logic [17:0] m_hi [DEPTH];
  bit          e_v  [2];
  logic [17:0] e_lo [2];
  logic [17:0] e_hi [2];

  function automatic logic [17:0] mix(logic [17:0] o, logic [17:0] n, logic [1:0] b_n);
    logic [17:0] r;
    r = o;
    if (!b_n[0]) r[8:0]  = n[8:0];
    if (!b_n[1]) r[17:9] = n[17:9];
    return r;
  endfunction

  task automatic chk(input logic [17:0] act, input logic [17:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // one clock period: read request on the rising edge, write on the falling edge;
  // checks the two output words of the read issued two periods earlier
  task automatic period(input bit rd, input logic [AW-1:0] ra,
                        input bit wr, input logic [AW-1:0] wa,
                        input logic [17:0] d0, input logic [1:0] b0,
                        input logic [17:0] d1, input logic [1:0] b1);
    @(negedge clk); #1;
    chk(rdata, e_v[1] ? e_lo[1] : 18'h0, "first word");
    addr = ra; rd_sel_n = !rd; wdata = d0; bw_n = b0;
    @(posedge clk); #1;
    chk(rdata, e_v[1] ? e_hi[1] : 18'h0, "second word");
    addr = wa; wr_sel_n = !wr; wdata = d1; bw_n = b1;
    e_v[1] = e_v[0]; e_lo[1] = e_lo[0]; e_hi[1] = e_hi[0];
    if (wr) begin
      m_lo[wa] = mix(m_lo[wa], d0, b0);
      m_hi[wa] = mix(m_hi[wa], d1, b1);
    end
    e_v[0] = rd;
    if (rd) begin
      e_lo[0] = m_lo[ra];
      e_hi[0] = m_hi[ra];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) period(0, '0, 0, '0, 18'h3FFFF, 2'b11, 18'h3FFFF, 2'b11);
  endtask

  // R1: output quiet during and after reset
  task automatic t_reset();
    cur_req = "R1";
    #3;
    chk(rdata, 18'h0, "during reset");
    idle(4);
  endtask

  // R9 and R3: fill every location, reading the previous one each period
  task automatic t_fill();
    cur_req = "R9";
    for (int i = 0; i < DEPTH; i++)
      period(i > 0, AW'(i - 1), 1, AW'(i),
             18'(i * 1031 + 5), 2'b00, 18'(i * 777 + 'h2A000), 2'b00);
    idle(2);
    cur_req = "R3";
    period(1, AW'(DEPTH - 1), 0, '0, 18'h0, 2'b11, 18'h0, 2'b11);
    period(1, 6'd5, 0, '0, 18'h0, 2'b11, 18'h0, 2'b11);
    idle(2);
  endtask

  // R2: a single read, surrounded by idle slots that must stay zero
  task automatic t_latency();
    cur_req = "R2";
    idle(1);
    period(1, 6'd9, 0, '0, 18'h0, 2'b11, 18'h0, 2'b11);
    idle(3);
  endtask

  // R4: read one location, write another in the same period
  task automatic t_concurrent();
    cur_req = "R4";
    period(1, 6'd3, 1, 6'd10, 18'h1A5A5, 2'b00, 18'h25A5A, 2'b00);
    period(1, 6'd10, 0, '0, 18'h0, 2'b11, 18'h0, 2'b11);
    idle(2);
  endtask

  // R5: lane enables taken separately with each word
  task automatic t_mask();
    cur_req = "R5";
    period(0, '0, 1, 6'd20, 18'h3FFFF, 2'b00, 18'h3FFFF, 2'b00);
    period(0, '0, 1, 6'd20, 18'h00000, 2'b10, 18'h00000, 2'b01);
    period(1, 6'd20, 1, 6'd21, 18'h12345, 2'b01, 18'h2ABCD, 2'b10);
    period(1, 6'd21, 0, '0, 18'h0, 2'b11, 18'h0, 2'b11);
    idle(2);
  endtask

  // R6: same location read and written in one period
  task automatic t_same();
    cur_req = "R6";
    period(0, '0, 1, 6'd30, 18'h11111, 2'b00, 18'h22222, 2'b00);
    idle(1);
    period(1, 6'd30, 1, 6'd30, 18'h3C3C3, 2'b01, 18'h0F0F0, 2'b10);
    period(1, 6'd31, 1, 6'd31, 18'h13579, 2'b00, 18'h2468A, 2'b00);
    period(1, 6'd30, 0, '0, 18'h0, 2'b11, 18'h0, 2'b11);
    idle(2);
  endtask

  // R7: deselected write stores nothing; deselected read drives nothing
  task automatic t_desel();
    cur_req = "R7";
    period(0, 6'd3, 0, 6'd3, 18'h3DEAD, 2'b00, 18'h0BEEF, 2'b00);
    period(0, 6'd3, 0, '0, 18'h0, 2'b00, 18'h0, 2'b00);
    period(1, 6'd3, 0, '0, 18'h0, 2'b11, 18'h0, 2'b11);
    idle(3);
  endtask

  // R8: back-to-back reads give a continuous stream
  task automatic t_stream();
    cur_req = "R8";
    for (int i = 0; i < 12; i++) period(1, AW'(40 + i), 0, '0, 18'h0, 2'b11, 18'h0, 2'b11);
    idle(2);
  endtask

  initial begin
    rst_n = 1'b1; addr = '0; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    wdata = '0; bw_n = 2'b11;
    for (int i = 0; i < 2; i++) begin e_v[i] = 0; e_lo[i] = '0; e_hi[i] = '0; end
    #2 rst_n = 1'b0;
    #30 rst_n = 1'b1;
    t_reset();
    t_fill();
    t_latency();
    t_concurrent();
    t_mask();
    t_same();
    t_desel();
    t_stream();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule